// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block is a fully associative translation buffer for a 32-bit virtual address space. Each of its slots (48 by default) holds one tag that covers two neighbouring virtual pages, an even one and an odd one. Each page in the pair has its own physical frame, cache attribute, write permission and valid flag. Page size is chosen per slot by a compare mask, from 4 KB up to 16 MB. An address-space identifier keeps the mappings of different processes apart. A slot is visible to every process only when both of its halves carry the global flag.

A translation is purely combinational. The caller presents a virtual address, the current address-space identifier and a load/store flag. In the same cycle it gets back a 36-bit physical address, a 3-bit cache attribute and one of three outcomes: hit, miss or invalid page. A write-protection fault flag and a multiple-match flag come back alongside. Software loads a slot in one clock: it gives an index and four 32-bit register images (tag word, page mask, even-page word, odd-page word). A separate probe port searches the slots with a tag word and returns the index of the matching slot, or a not-found code.

Top module: `pair_tlb_xlate`

## Requirements
- R1: After reset no slot matches anything: every lookup reports miss and every probe returns 0x8000_0000. Reset is synchronous and active high.
- R2: A clock edge with `wr_en` high and `wr_index` below the slot count replaces that whole slot. The tag word carries the pair number in bits 31:13 and the identifier in bits 7:0, and its bits 12:8 are ignored. The mask word carries the mask in bits 24:13. Each page word carries the frame number in bits 29:6, the attribute in 5:3, dirty in 2, valid in 1 and global in 0, and its bits 31:30 are ignored. A write whose index is at or above the slot count changes no slot.
- R3: A slot matches when the virtual address bits 31:13 equal its pair number at every position whose mask bit is clear. In addition, either the identifiers must be equal, or the global bit must have been set in both page words. Global set in only one page word gives no global behaviour.
- R4: The page within the pair is chosen by virtual address bit 12+k, where k is the number of set mask bits (mask set contiguously from bit 13). A 0 chooses the even page word and a 1 chooses the odd one.
- R5: On a hit, the physical address is the 24-bit frame number shifted left by 12. Its low 12+k bits are replaced by the same bits of the virtual address. The attribute output equals the selected page's attribute field.
- R6: When a slot matches but the selected page has valid clear, `lk_invalid` is 1, `lk_hit` is 0, and the address and attribute outputs are 0.
- R7: A store that hits a page with dirty clear raises `lk_modfault` while `lk_hit` stays 1. A load never raises it, and neither does a store to a dirty page.
- R8: When no slot matches, `lk_miss` is 1 and the address and attribute outputs are 0. Exactly one of hit, miss and invalid is 1 at all times.
- R9: When several slots match, the lowest-index slot supplies every result (including an invalid-page outcome) and `lk_multi` is 1. With a single match, `lk_multi` is 0.
- R10: The probe returns the lowest matching index, zero-extended, with bit 31 clear, using the same rule as R3. When nothing matches it returns exactly 0x8000_0000.
- R11: Lookup and probe results follow their inputs within the same cycle. A slot write becomes visible only after the clock edge that takes it; before that edge the old contents still translate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties all slots |
| wr_en | input | 1 | Load the slot named by `wr_index` at this edge |
| wr_index | input | IDX_W (6) | Slot to load |
| wr_tag_word | input | 32 | Pair number and address-space identifier image |
| wr_mask_word | input | 32 | Page-size mask image |
| wr_even_word | input | 32 | Even page frame/attribute/flags image |
| wr_odd_word | input | 32 | Odd page frame/attribute/flags image |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_store | input | 1 | 1 for a store access, 0 for a load |
| pr_tag_word | input | 32 | Tag word to search for |
| lk_pa | output | 36 | Physical address (0 unless hit) |
| lk_attr | output | 3 | Cache attribute of the page (0 unless hit) |
| lk_hit | output | 1 | Matching slot with valid page |
| lk_miss | output | 1 | No slot matches |
| lk_invalid | output | 1 | Matching slot but page not valid |
| lk_modfault | output | 1 | Store to a page without write permission |
| lk_multi | output | 1 | More than one slot matches |
| pr_result | output | 32 | Matching index, or 0x8000_0000 when none |

## Verification
A corrupted slot field is visible at the ports on the very first lookup or probe that touches that slot, in the same cycle. A wrong pair number or identifier turns into a miss or a wrong probe index. A wrong mask moves both the even/odd choice and the boundary between frame bits and offset bits in the physical address. A swapped or mis-sliced page word shows up as a wrong frame, attribute, fault or outcome flag. Errors in the write path show one edge after the write, and a wrong priority order only shows when two slots overlap. For these reasons the bench loads every slot with its own mask size, flag mix and identifier, walks both halves with loads and stores under matching and foreign identifiers, and then creates deliberate overlaps.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W     = 32;
    localparam int PA_W     = 36;
    localparam int ASID_W   = 8;
    localparam int PAGE_LSB = 12;
    localparam int VPN2_LSB = 13;
    localparam int VPN2_W   = VA_W - VPN2_LSB;
    localparam int MASK_W   = 12;
    localparam int PFN_W    = 24;
    localparam int ATTR_W   = 3;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
    } page_half_t;

    typedef struct packed {
        logic              used;
        logic [VPN2_W-1:0] vpn2;
        logic [MASK_W-1:0] mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        page_half_t        odd;
        page_half_t        even;
    } tlb_entry_t;

    // Page word image: frame 29:6, attribute 5:3, dirty 2, valid 1.
    function automatic page_half_t decode_page_word(input logic [31:0] w);
        page_half_t h;
        h.pfn   = w[29:6];
        h.attr  = w[5:3];
        h.dirty = w[2];
        h.valid = w[1];
        return h;
    endfunction

    function automatic tlb_entry_t build_entry(
        input logic [31:0] tag_w,
        input logic [31:0] mask_w,
        input logic [31:0] even_w,
        input logic [31:0] odd_w
    );
        tlb_entry_t e;
        e.used = 1'b1;
        e.vpn2 = tag_w[VA_W-1:VPN2_LSB];
        e.mask = mask_w[VPN2_LSB+MASK_W-1:VPN2_LSB];
        e.asid = tag_w[ASID_W-1:0];
        e.glob = even_w[0] & odd_w[0];
        e.even = decode_page_word(even_w);
        e.odd  = decode_page_word(odd_w);
        return e;
    endfunction

    // Bit just above the page offset; it moves up one place per mask bit.
    function automatic logic odd_select(input logic [VA_W-1:0] va,
                                        input logic [MASK_W-1:0] mask);
        logic s;
        s = va[PAGE_LSB];
        for (int b = 0; b < MASK_W; b++) begin
            if (mask[b]) s = va[VPN2_LSB + b];
        end
        return s;
    endfunction

    // Physical address bits that come from the virtual address.
    function automatic logic [PA_W-1:0] offset_keep(input logic [MASK_W-1:0] mask);
        return {{(PA_W-MASK_W-PAGE_LSB){1'b0}}, mask, {PAGE_LSB{1'b1}}};
    endfunction

    // Pair-number bits that take part in the compare.
    function automatic logic [VPN2_W-1:0] vpn_care(input logic [MASK_W-1:0] mask);
        return ~{{(VPN2_W-MASK_W){1'b0}}, mask};
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 48,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_index,
    input  tlb_entry_t                   wr_entry,
    output tlb_entry_t [NUM_ENTRIES-1:0] entries
);

    // One register per slot; an index with no slot selects nothing.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        tlb_entry_t slot_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (wr_en && (wr_index == IDX_W'(g))) begin
                slot_q <= wr_entry;
            end
        end

        assign entries[g] = slot_q;
    end

endmodule

// File: rtl/tlb_tag_compare.sv
module tlb_tag_compare
    import tlb_pkg::*;
(
    input  tlb_entry_t        entry,
    input  logic [VPN2_W-1:0] vpn2,
    input  logic [ASID_W-1:0] asid,
    output logic              match
);

    logic vpn_eq;
    logic asid_ok;

    always_comb begin
        vpn_eq  = ((vpn2 ^ entry.vpn2) & vpn_care(entry.mask)) == '0;
        asid_ok = entry.glob || (asid == entry.asid);
        match   = entry.used && vpn_eq && asid_ok;
    end

endmodule

// File: rtl/tlb_first_match.sv
module tlb_first_match #(
    parameter int NUM_ENTRIES = 48,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] hits,
    output logic                   found,
    output logic [IDX_W-1:0]       index,
    output logic                   several
);

    always_comb begin
        found = |hits;
        index = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) index = IDX_W'(i);
        end
        several = (hits & (hits - NUM_ENTRIES'(1))) != '0;
    end

endmodule

// File: rtl/tlb_page_select.sv
module tlb_page_select
    import tlb_pkg::*;
(
    input  tlb_entry_t        entry,
    input  logic [VA_W-1:0]   va,
    output logic [PA_W-1:0]   pa,
    output logic [ATTR_W-1:0] attr,
    output logic              valid,
    output logic              dirty
);

    page_half_t      half;
    logic [PA_W-1:0] keep;
    logic [PA_W-1:0] frame_base;

    always_comb begin
        half       = odd_select(va, entry.mask) ? entry.odd : entry.even;
        keep       = offset_keep(entry.mask);
        frame_base = {half.pfn, {PAGE_LSB{1'b0}}};
        pa         = (frame_base & ~keep) | ({{(PA_W-VA_W){1'b0}}, va} & keep);
        attr       = half.attr;
        valid      = half.valid;
        dirty      = half.dirty;
    end

endmodule

// File: rtl/pair_tlb_xlate.sv
module pair_tlb_xlate
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 48,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [31:0]       wr_tag_word,
    input  logic [31:0]       wr_mask_word,
    input  logic [31:0]       wr_even_word,
    input  logic [31:0]       wr_odd_word,
    input  logic [31:0]       lk_va,
    input  logic [7:0]        lk_asid,
    input  logic              lk_store,
    input  logic [31:0]       pr_tag_word,
    output logic [35:0]       lk_pa,
    output logic [2:0]        lk_attr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_invalid,
    output logic              lk_modfault,
    output logic              lk_multi,
    output logic [31:0]       pr_result
);

    tlb_entry_t [NUM_ENTRIES-1:0] entries;
    tlb_entry_t                   new_entry;

    logic [NUM_ENTRIES-1:0] lk_vec;
    logic [NUM_ENTRIES-1:0] pr_vec;
    logic                   lk_found, lk_many;
    logic [IDX_W-1:0]       lk_idx;
    logic                   pr_found, pr_many;
    logic [IDX_W-1:0]       pr_idx;

    tlb_entry_t        chosen;
    logic [PA_W-1:0]   sel_pa;
    logic [ATTR_W-1:0] sel_attr;
    logic              sel_valid, sel_dirty;

    assign new_entry = build_entry(wr_tag_word, wr_mask_word, wr_even_word, wr_odd_word);

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_index (wr_index),
        .wr_entry (new_entry),
        .entries  (entries)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        tlb_tag_compare u_lk_cmp (
            .entry (entries[g]),
            .vpn2  (lk_va[VA_W-1:VPN2_LSB]),
            .asid  (lk_asid),
            .match (lk_vec[g])
        );
        tlb_tag_compare u_pr_cmp (
            .entry (entries[g]),
            .vpn2  (pr_tag_word[VA_W-1:VPN2_LSB]),
            .asid  (pr_tag_word[ASID_W-1:0]),
            .match (pr_vec[g])
        );
    end

    tlb_first_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk_pick (
        .hits    (lk_vec),
        .found   (lk_found),
        .index   (lk_idx),
        .several (lk_many)
    );

    tlb_first_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_pr_pick (
        .hits    (pr_vec),
        .found   (pr_found),
        .index   (pr_idx),
        .several (pr_many)
    );

    assign chosen = entries[lk_idx];

    tlb_page_select u_page (
        .entry (chosen),
        .va    (lk_va),
        .pa    (sel_pa),
        .attr  (sel_attr),
        .valid (sel_valid),
        .dirty (sel_dirty)
    );

    always_comb begin
        lk_miss     = !lk_found;
        lk_hit      = lk_found && sel_valid;
        lk_invalid  = lk_found && !sel_valid;
        lk_modfault = lk_hit && lk_store && !sel_dirty;
        lk_multi    = lk_many;
        lk_pa       = lk_hit ? sel_pa : '0;
        lk_attr     = lk_hit ? sel_attr : '0;
        pr_result   = pr_found ? {1'b0, 31'(pr_idx)} : 32'h8000_0000;
    end

    logic unused_ok;
    assign unused_ok = pr_many;

endmodule

// File: rtl/tlb_xlate_checks.sv
module tlb_xlate_checks #(
    parameter int NUM_ENTRIES = 48
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] lk_va,
    input logic        lk_store,
    input logic [35:0] lk_pa,
    input logic [2:0]  lk_attr,
    input logic        lk_hit,
    input logic        lk_miss,
    input logic        lk_invalid,
    input logic        lk_modfault,
    input logic        lk_multi,
    input logic [31:0] pr_result
);

    a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $countones({lk_hit, lk_miss, lk_invalid}) == 1);

    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        lk_miss |-> (lk_pa == '0 && lk_attr == '0));

    a_r6_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        lk_invalid |-> (lk_pa == '0 && lk_attr == '0));

    a_r7_fault_needs_store: assert property (@(posedge clk) disable iff (rst)
        lk_modfault |-> (lk_hit && lk_store));

    a_r5_offset_kept: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

    a_r9_multi_matches: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> !lk_miss);

    a_r10_notfound_code: assert property (@(posedge clk) disable iff (rst)
        pr_result[31] |-> (pr_result[30:0] == '0));

    a_r10_index_range: assert property (@(posedge clk) disable iff (rst)
        !pr_result[31] |-> (pr_result[30:0] < 31'(NUM_ENTRIES)));

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lk_miss && pr_result == 32'h8000_0000));

endmodule

bind pair_tlb_xlate tlb_xlate_checks #(.NUM_ENTRIES(NUM_ENTRIES)) u_checks (.*);

// File: tb/tb_pair_tlb_xlate.sv
module tb_pair_tlb_xlate;

    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_index = '0;
    logic [31:0] wr_tag_word = '0, wr_mask_word = '0, wr_even_word = '0, wr_odd_word = '0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic [31:0] pr_tag_word = '0;
    logic [35:0] lk_pa;
    logic [2:0]  lk_attr;
    logic        lk_hit, lk_miss, lk_invalid, lk_modfault, lk_multi;
    logic [31:0] pr_result;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pair_tlb_xlate dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Stimulus pattern per slot
    function automatic logic [7:0] asid_of(int i); return 8'((i * 7 + 3) % 256); endfunction
    function automatic int k_of(int i); return 2 * (i % 7); endfunction
    function automatic logic [31:0] tag_of(int i);
        return (32'(i) << 25) | 32'(asid_of(i)) | ((i % 3 == 0) ? 32'h1F00 : 32'h0);
    endfunction
    function automatic logic [31:0] mask_of(int i);
        return ((32'd1 << k_of(i)) - 32'd1) << 13;
    endfunction
    function automatic logic [23:0] pfn_of(int i, int h);
        logic [23:0] p0;
        p0 = 24'(i * 32'hA5A5 + 32'h123);
        return h ? (~p0 ^ 24'(i)) : p0;
    endfunction
    function automatic logic [2:0] c_of(int i, int h); return h ? 3'((i + 3) % 8) : 3'(i % 8); endfunction
    function automatic logic d_of(int i, int h); return h ? 1'((i >> 1) & 1) : 1'(i & 1); endfunction
    function automatic logic v_of(int i, int h); return h ? (i % 6 != 5) : (i % 4 != 3); endfunction
    function automatic logic g_of(int i, int h);
        return h ? ((i % 5 == 0) || (i % 7 == 1)) : (i % 5 == 0);
    endfunction
    function automatic logic [31:0] word_of(int i, int h);
        return ((i % 2) ? 32'hC000_0000 : 32'h0) | (32'(pfn_of(i, h)) << 6) |
               (32'(c_of(i, h)) << 3) | (32'(d_of(i, h)) << 2) |
               (32'(v_of(i, h)) << 1) | 32'(g_of(i, h));
    endfunction
    function automatic logic [31:0] va_of(int i, int h);
        int s;
        logic [31:0] off;
        s   = 12 + k_of(i);
        off = (32'(i) * 32'h0013_579B + 32'(h) * 32'h777) & ((32'd1 << s) - 32'd1);
        return (32'(i) << 25) | (32'(h) << s) | off;
    endfunction
    function automatic logic [35:0] pa_of(int i, int h, logic [31:0] va);
        logic [35:0] keep;
        keep = (36'(mask_of(i)) >> 1) | 36'hFFF;
        return ((36'(pfn_of(i, h)) << 12) & ~keep) | (36'(va) & keep);
    endfunction

    task automatic write_slot(input int idx, input logic [31:0] t, m, e, o);
        @(negedge clk);
        wr_index = 6'(idx); wr_tag_word = t; wr_mask_word = m;
        wr_even_word = e; wr_odd_word = o; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic st);
        lk_va = va; lk_asid = asid; lk_store = st;
        #2;
    endtask

    task automatic probe(input logic [31:0] t);
        pr_tag_word = t;
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: empty after reset
        for (int i = 0; i < 4; i++) begin
            look(32'(i) * 32'h1234_5000, 8'(i), 1'b0);
            chk("R1", "miss after reset", lk_miss, 1);
            chk("R1", "hit after reset", lk_hit, 0);
            probe(32'(i) << 13);
            chk("R1", "probe after reset", pr_result, 32'h8000_0000);
        end

        for (int i = 0; i < N; i++)
            write_slot(i, tag_of(i), mask_of(i), word_of(i, 0), word_of(i, 1));
        @(negedge clk);

        // R2..R8, R10: sweep every slot, both halves, load/store, own and foreign ASID
        for (int i = 0; i < N; i++) begin
            for (int h = 0; h < 2; h++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int st = 0; st < 2; st++) begin
                        logic [7:0] asid;
                        logic matched, ehit;
                        logic [31:0] va;
                        asid    = a ? (asid_of(i) ^ 8'h55) : asid_of(i);
                        matched = (a == 0) || (g_of(i, 0) && g_of(i, 1));
                        ehit    = matched && v_of(i, h);
                        va      = va_of(i, h);
                        look(va, asid, 1'(st));
                        chk("R3", "miss", lk_miss, !matched);
                        chk("R4", "hit of selected half", lk_hit, ehit);
                        chk("R6", "invalid", lk_invalid, matched && !v_of(i, h));
                        chk("R7", "modfault", lk_modfault, ehit && st == 1 && !d_of(i, h));
                        chk("R5", "pa", lk_pa, ehit ? pa_of(i, h, va) : 36'h0);
                        chk("R5", "attr", lk_attr, ehit ? c_of(i, h) : 3'h0);
                        chk("R9", "single match", lk_multi, 0);
                    end
                end
            end
            probe(tag_of(i));
            chk("R10", "probe own", pr_result, 32'(i));
            probe(tag_of(i) ^ 32'h55);
            chk("R10", "probe foreign asid", pr_result,
                (g_of(i, 0) && g_of(i, 1)) ? 32'(i) : 32'h8000_0000);
        end

        // R2: out-of-range indices change nothing
        write_slot(50, (32'd60 << 25) | 32'd1, 32'h0, 32'h0000_0042, 32'h0000_0042);
        write_slot(63, (32'd60 << 25) | 32'd1, 32'h0, 32'h0000_0042, 32'h0000_0042);
        look(32'd60 << 25, 8'd1, 1'b0);
        chk("R2", "ignored index miss", lk_miss, 1);
        probe((32'd60 << 25) | 32'd1);
        chk("R2", "ignored index probe", pr_result, 32'h8000_0000);
        probe(tag_of(2));
        chk("R2", "slot 2 intact", pr_result, 32'd2);

        // R11: write takes effect only after the edge
        @(negedge clk);
        wr_index = 6'd5; wr_tag_word = (32'd61 << 25) | 32'd9; wr_mask_word = 32'h0;
        wr_even_word = 32'h0000_0046; wr_odd_word = 32'h0000_0046; wr_en = 1'b1;
        look(va_of(5, 0), asid_of(5), 1'b0);
        chk("R11", "old still hits before edge", lk_hit, 1);
        look(32'd61 << 25, 8'd9, 1'b0);
        chk("R11", "new misses before edge", lk_miss, 1);
        @(negedge clk);
        wr_en = 1'b0;
        look(va_of(5, 0), asid_of(5), 1'b0);
        chk("R11", "old gone after edge", lk_miss, 1);
        look((32'd61 << 25) | 32'h0000_0ABC, 8'd9, 1'b0);
        chk("R11", "new hits after edge", lk_hit, 1);
        chk("R11", "new pa", lk_pa, 36'h0_0000_0ABC | (36'h1 << 12));

        // R9: overlap slot 40 onto slot 7; lowest index wins
        write_slot(40, tag_of(7), mask_of(7), 32'h02AF_37BE, 32'h02AF_37BE);
        look(va_of(7, 0), asid_of(7), 1'b0);
        chk("R9", "multi flag", lk_multi, 1);
        chk("R9", "lowest slot invalid half", lk_invalid, 1);
        look(va_of(7, 1), asid_of(7), 1'b0);
        chk("R9", "multi flag odd", lk_multi, 1);
        chk("R9", "lowest slot pa", lk_pa, pa_of(7, 1, va_of(7, 1)));
        probe(tag_of(7));
        chk("R10", "probe lowest of two", pr_result, 32'd7);

        // R1: reset mid-run empties everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        look(va_of(7, 1), asid_of(7), 1'b0);
        chk("R1", "miss after second reset", lk_miss, 1);
        probe(tag_of(3));
        chk("R1", "probe after second reset", pr_result, 32'h8000_0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule